// File: doc/BRIEF.md
# Machine-Mode CSR Register Unit

This unit keeps the five machine-mode control and status registers of a small RISC-V core: the interrupt-enable mask (MIE), the trap vector base (MTVEC), the scratch word (MSCRATCH), the exception PC (MEPC) and the trap cause (MCAUSE). The core presents a CSR instruction as a 12-bit address, a 3-bit operation, a register operand, a 5-bit unsigned immediate and a write strobe. The unit returns the addressed register's present value on a combinational read port. It applies one of six read-modify-write operations to that same value on the next rising clock edge.

A trap strobe captures the faulting PC into MEPC and the cause code into MCAUSE. On those two registers the capture takes priority over an instruction write in the same cycle. MIE, MTVEC and MEPC are also driven continuously on dedicated outputs to the rest of the core. All ports are plain control and data pins with no handshake. An instruction is accepted in every cycle in which the write strobe is high, so there is never back-pressure.

Top module: `mcsr_unit`

## Requirements
- R1: A synchronous reset clears all five registers to zero. After reset every mapped address reads zero and mie_o, mtvec_o and mepc_o are zero.
- R2: Operation 3'b001 loads the register operand into the addressed register. Operation 3'b101 loads the immediate, zero-extended to 32 bits.
- R3: Operation 3'b010 ORs the register operand into the present value. Operation 3'b110 does the same with the zero-extended immediate.
- R4: Operation 3'b011 ANDs the present value with the inverse of the register operand. Operation 3'b111 does the same with the zero-extended immediate.
- R5: A register changes only at a rising clock edge with csr_we_i high. Within the cycle of the write, rdata_o still shows the old value, and from the next cycle it shows the new value. With csr_we_i low, nothing changes.
- R6: Writes on consecutive cycles to one address each take effect, and each builds on the result of the previous one.
- R7: With trap_i high, at the next edge MEPC takes trap_pc_i and MCAUSE takes trap_cause_i.
- R8: If trap_i is high in the same cycle as an instruction write to MEPC (0x341) or MCAUSE (0x342), the trap values win. An instruction write to another register in that cycle still takes effect.
- R9: MEPC holds unless trap_i is high or an instruction writes address 0x341. MIE holds unless an instruction writes 0x304. MTVEC holds unless an instruction writes 0x305.
- R10: The register addresses are MIE 0x304, MTVEC 0x305, MSCRATCH 0x340, MEPC 0x341 and MCAUSE 0x342. Any other address reads zero and its writes change no register.
- R11: Operation codes 3'b000 and 3'b100 change no register, even with csr_we_i high.
- R12: mie_o, mtvec_o and mepc_o always equal the content that reads back from addresses 0x304, 0x305 and 0x341.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, active high |
| csr_addr_i | input | 12 | CSR address of the instruction |
| csr_op_i | input | 3 | Operation code (see R2 to R4 and R11) |
| csr_src_i | input | 32 | Register operand |
| csr_uimm_i | input | 5 | Unsigned immediate operand |
| csr_we_i | input | 1 | Instruction write strobe |
| trap_i | input | 1 | Trap capture strobe |
| trap_pc_i | input | 32 | PC to capture into MEPC |
| trap_cause_i | input | 32 | Cause code to capture into MCAUSE |
| rdata_o | output | 32 | Present content of the addressed register |
| mie_o | output | 32 | MIE content |
| mtvec_o | output | 32 | MTVEC content |
| mepc_o | output | 32 | MEPC content |

## Verification
The trap capture and an instruction write can land in the same cycle. They conflict only when the instruction targets MEPC or MCAUSE. The bench drives trap_i together with write, set and clear operations aimed at both trap registers and at MIE. It judges by reading back all five registers in the following cycle: the trap registers must hold the trap values, and the unrelated register must hold the instruction result. A long random mix of addresses, operations, unmapped addresses, invalid codes and trap strobes repeats this collision many times against a scoreboard model.

// File: rtl/mcsr_pkg.sv
package mcsr_pkg;

  localparam int ADDR_W  = 12;
  localparam int NUM_CSR = 5;

  // Register slots inside the unit
  localparam int IDX_MIE      = 0;
  localparam int IDX_MTVEC    = 1;
  localparam int IDX_MSCRATCH = 2;
  localparam int IDX_MEPC     = 3;
  localparam int IDX_MCAUSE   = 4;

  // Architectural CSR addresses, indexed by slot
  localparam logic [ADDR_W-1:0] CSR_ADDR [NUM_CSR] = '{
    12'h304, 12'h305, 12'h340, 12'h341, 12'h342
  };

  // Operation encodings
  localparam logic [2:0] OP_WR   = 3'b001;
  localparam logic [2:0] OP_SET  = 3'b010;
  localparam logic [2:0] OP_CLR  = 3'b011;
  localparam logic [2:0] OP_WRI  = 3'b101;
  localparam logic [2:0] OP_SETI = 3'b110;
  localparam logic [2:0] OP_CLRI = 3'b111;

  function automatic logic slot_takes_trap(int idx);
    return (idx == IDX_MEPC) || (idx == IDX_MCAUSE);
  endfunction

endpackage

// File: rtl/mcsr_decode.sv
module mcsr_decode
  import mcsr_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  output logic [NUM_CSR-1:0] sel_o,
  output logic               hit_o
);

  for (genvar k = 0; k < NUM_CSR; k++) begin : g_match
    assign sel_o[k] = (addr_i == CSR_ADDR[k]);
  end

  assign hit_o = |sel_o;

  always_comb begin
    assert ($onehot0(sel_o));
  end

endmodule

// File: rtl/mcsr_rmw.sv
module mcsr_rmw
  import mcsr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int UIMM_W = 5
) (
  input  logic [2:0]        op_i,
  input  logic [XLEN-1:0]   cur_i,
  input  logic [XLEN-1:0]   src_i,
  input  logic [UIMM_W-1:0] uimm_i,
  output logic [XLEN-1:0]   next_o,
  output logic              op_ok_o
);

  localparam int PAD_W = XLEN - UIMM_W;

  logic [XLEN-1:0] operand;
  logic            use_imm;

  // op[2] selects the immediate form; op[1:0] selects the action
  assign use_imm = op_i[2];
  assign operand = use_imm ? {{PAD_W{1'b0}}, uimm_i} : src_i;

  always_comb begin
    next_o  = cur_i;
    op_ok_o = 1'b1;
    unique case (op_i[1:0])
      2'b01:   next_o = operand;
      2'b10:   next_o = cur_i | operand;
      2'b11:   next_o = cur_i & ~operand;
      default: op_ok_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/mcsr_cell.sv
module mcsr_cell #(
  parameter int XLEN      = 32,
  parameter bit TRAP_LOAD = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            wr_en_i,
  input  logic [XLEN-1:0] wr_data_i,
  input  logic            trap_en_i,
  input  logic [XLEN-1:0] trap_data_i,
  output logic [XLEN-1:0] q_o
);

  logic trap_take;
  assign trap_take = TRAP_LOAD ? trap_en_i : 1'b0;

  always_ff @(posedge clk_i) begin
    if (rst_i)          q_o <= '0;
    else if (trap_take) q_o <= trap_data_i;
    else if (wr_en_i)   q_o <= wr_data_i;
  end

  p_cell_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(wr_en_i || trap_take) |=> $stable(q_o));

  if (TRAP_LOAD) begin : g_trap_chk
    p_trap_over_write_r8: assert property (@(posedge clk_i) disable iff (rst_i)
      trap_en_i |=> (q_o == $past(trap_data_i)));
  end

endmodule

// File: rtl/mcsr_unit.sv
module mcsr_unit
  import mcsr_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int UIMM_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [2:0]        csr_op_i,
  input  logic [XLEN-1:0]   csr_src_i,
  input  logic [UIMM_W-1:0] csr_uimm_i,
  input  logic              csr_we_i,
  input  logic              trap_i,
  input  logic [XLEN-1:0]   trap_pc_i,
  input  logic [XLEN-1:0]   trap_cause_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic [XLEN-1:0]   mie_o,
  output logic [XLEN-1:0]   mtvec_o,
  output logic [XLEN-1:0]   mepc_o
);

  logic [NUM_CSR-1:0] sel;
  logic               hit;
  logic [XLEN-1:0]    q [NUM_CSR];
  logic [XLEN-1:0]    trap_val [NUM_CSR];
  logic [XLEN-1:0]    next_val;
  logic               op_ok;
  logic               wr_go;

  mcsr_decode u_dec (
    .addr_i (csr_addr_i),
    .sel_o  (sel),
    .hit_o  (hit)
  );

  // Read mux: AND-OR over the one-hot select
  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < NUM_CSR; k++) begin
      rdata_o = rdata_o | (sel[k] ? q[k] : '0);
    end
  end

  // The modify step works on the same value that is being read out
  mcsr_rmw #(.XLEN(XLEN), .UIMM_W(UIMM_W)) u_rmw (
    .op_i    (csr_op_i),
    .cur_i   (rdata_o),
    .src_i   (csr_src_i),
    .uimm_i  (csr_uimm_i),
    .next_o  (next_val),
    .op_ok_o (op_ok)
  );

  assign wr_go = csr_we_i & hit & op_ok;

  for (genvar k = 0; k < NUM_CSR; k++) begin : g_csr
    localparam bit TAKES_TRAP = slot_takes_trap(k);
    assign trap_val[k] = (k == IDX_MEPC) ? trap_pc_i : trap_cause_i;

    mcsr_cell #(.XLEN(XLEN), .TRAP_LOAD(TAKES_TRAP)) u_cell (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .wr_en_i     (wr_go & sel[k]),
      .wr_data_i   (next_val),
      .trap_en_i   (trap_i),
      .trap_data_i (trap_val[k]),
      .q_o         (q[k])
    );
  end

  assign mie_o   = q[IDX_MIE];
  assign mtvec_o = q[IDX_MTVEC];
  assign mepc_o  = q[IDX_MEPC];

  // ---------------- assertions ----------------
  p_reset_clear_r1: assert property (@(posedge clk_i)
    rst_i |=> (mie_o == '0 && mtvec_o == '0 && mepc_o == '0));

  p_write_next_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (csr_we_i && csr_addr_i == 12'h305 && csr_op_i == OP_WR)
      |=> (mtvec_o == $past(csr_src_i)));

  p_trap_capture_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    trap_i |=> (mepc_o == $past(trap_pc_i)));

  p_mepc_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(trap_i || (csr_we_i && csr_addr_i == 12'h341)) |=> $stable(mepc_o));

  p_mie_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(csr_we_i && csr_addr_i == 12'h304) |=> $stable(mie_o));

  p_mtvec_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
    !(csr_we_i && csr_addr_i == 12'h305) |=> $stable(mtvec_o));

  p_unmapped_zero_r10: assert property (@(posedge clk_i) disable iff (rst_i)
    !hit |-> (rdata_o == '0));

  p_bad_op_r11: assert property (@(posedge clk_i) disable iff (rst_i)
    (!trap_i && csr_op_i[1:0] == 2'b00)
      |=> ($stable(mie_o) && $stable(mtvec_o) && $stable(mepc_o)));

endmodule

// File: tb/sim_mcsr_unit.sv
module sim_mcsr_unit;

  localparam logic [11:0] A_MIE = 12'h304, A_MTVEC = 12'h305, A_MSCR = 12'h340,
                          A_MEPC = 12'h341, A_MCAUSE = 12'h342, A_NONE = 12'h300;

  logic        clk = 1'b0;
  logic        rst;
  logic [11:0] addr;
  logic [2:0]  op;
  logic [31:0] src;
  logic [4:0]  uimm;
  logic        we;
  logic        trap;
  logic [31:0] tpc;
  logic [31:0] tcause;
  logic [31:0] rdata, mie, mtvec, mepc;

  always #2 clk = ~clk;

  mcsr_unit u0 (
    .clk_i(clk), .rst_i(rst), .csr_addr_i(addr), .csr_op_i(op),
    .csr_src_i(src), .csr_uimm_i(uimm), .csr_we_i(we), .trap_i(trap),
    .trap_pc_i(tpc), .trap_cause_i(tcause), .rdata_o(rdata),
    .mie_o(mie), .mtvec_o(mtvec), .mepc_o(mepc)
  );

  typedef struct {
    string       req;
    int          kind;
    logic [31:0] exp;
  } item_t;

  item_t q[$];
  bit    go = 1'b0;
  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  logic [31:0] m_mie = '0, m_mtvec = '0, m_mscr = '0, m_mepc = '0, m_mcause = '0;

  function automatic logic [31:0] m_read(logic [11:0] a);
    case (a)
      A_MIE:    return m_mie;
      A_MTVEC:  return m_mtvec;
      A_MSCR:   return m_mscr;
      A_MEPC:   return m_mepc;
      A_MCAUSE: return m_mcause;
      default:  return '0;
    endcase
  endfunction

  // Monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      wait (go);
      while (q.size() > 0) begin
        item_t it;
        logic [31:0] act;
        string nm;
        it = q.pop_front();
        case (it.kind)
          0: begin act = rdata; nm = "rdata_o"; end
          1: begin act = mie;   nm = "mie_o";   end
          2: begin act = mtvec; nm = "mtvec_o"; end
          default: begin act = mepc; nm = "mepc_o"; end
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s %s actual=%08h expected=%08h", it.req, nm, act, it.exp);
        end
      end
      go = 1'b0;
    end
  end

  // Driver side: queue the expected values for the current state, then hand over
  task automatic expect_now(string req, logic [11:0] a);
    q.push_back('{req, 0, m_read(a)});
    q.push_back('{req, 1, m_mie});
    q.push_back('{req, 2, m_mtvec});
    q.push_back('{req, 3, m_mepc});
    go = 1'b1;
    wait (!go);
  endtask

  task automatic apply(string req, bit w, logic [11:0] a, logic [2:0] o,
                       logic [31:0] s, logic [4:0] im, bit tr,
                       logic [31:0] pc, logic [31:0] cs);
    logic [31:0] cur, opd, nv;
    bit ok;
    @(negedge clk);
    we = w; addr = a; op = o; src = s; uimm = im; trap = tr; tpc = pc; tcause = cs;
    #1;
    expect_now(req, a);          // R5: old value still visible in the write cycle
    cur = m_read(a);
    opd = o[2] ? {27'd0, im} : s;
    ok  = 1'b1;
    nv  = cur;
    case (o[1:0])
      2'b01: nv = opd;
      2'b10: nv = cur | opd;
      2'b11: nv = cur & ~opd;
      default: ok = 1'b0;
    endcase
    if (w && ok) begin
      case (a)
        A_MIE:    m_mie = nv;
        A_MTVEC:  m_mtvec = nv;
        A_MSCR:   m_mscr = nv;
        A_MEPC:   if (!tr) m_mepc = nv;
        A_MCAUSE: if (!tr) m_mcause = nv;
        default:  ;
      endcase
    end
    if (tr) begin
      m_mepc = pc;
      m_mcause = cs;
    end
  endtask

  task automatic idle_read(string req, logic [11:0] a);
    @(negedge clk);
    we = 1'b0; trap = 1'b0; addr = a; op = 3'b000;
    #1;
    expect_now(req, a);
  endtask

  task automatic read_all(string req);
    idle_read(req, A_MIE);
    idle_read(req, A_MTVEC);
    idle_read(req, A_MSCR);
    idle_read(req, A_MEPC);
    idle_read(req, A_MCAUSE);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog all-requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; we = 1'b0; trap = 1'b0; addr = '0; op = '0; src = '0;
    uimm = '0; tpc = '0; tcause = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state, R12 outputs track reads
    read_all("R1");

    // R2: plain and immediate write (immediate zero-extended)
    apply("R2", 1, A_MTVEC, 3'b001, 32'h8000_0100, 5'd0, 0, 0, 0);
    apply("R2", 1, A_MSCR, 3'b101, 32'hFFFF_FFFF, 5'h1F, 0, 0, 0);
    read_all("R2");

    // R3: set forms
    apply("R3", 1, A_MIE, 3'b010, 32'h0000_0888, 5'd0, 0, 0, 0);
    apply("R3", 1, A_MIE, 3'b110, 32'hFFFF_0000, 5'h03, 0, 0, 0);
    read_all("R3");

    // R4: clear forms
    apply("R4", 1, A_MIE, 3'b011, 32'h0000_0800, 5'd0, 0, 0, 0);
    apply("R4", 1, A_MSCR, 3'b111, 32'hFFFF_FFFF, 5'h05, 0, 0, 0);
    read_all("R4");

    // R5: no write without strobe
    apply("R5", 0, A_MTVEC, 3'b001, 32'hDEAD_BEEF, 5'd0, 0, 0, 0);
    read_all("R5");

    // R6: back-to-back builds on the previous result
    apply("R6", 1, A_MSCR, 3'b001, 32'h0000_0001, 5'd0, 0, 0, 0);
    apply("R6", 1, A_MSCR, 3'b010, 32'h0000_0002, 5'd0, 0, 0, 0);
    apply("R6", 1, A_MSCR, 3'b110, 32'd0, 5'h10, 0, 0, 0);
    apply("R6", 1, A_MSCR, 3'b011, 32'h0000_0001, 5'd0, 0, 0, 0);
    idle_read("R6", A_MSCR);

    // R7: trap capture
    apply("R7", 0, A_MIE, 3'b000, 0, 0, 1, 32'h0000_1234, 32'h8000_000B);
    read_all("R7");

    // R8: trap collides with writes to MEPC / MCAUSE; MIE write still lands
    apply("R8", 1, A_MEPC, 3'b001, 32'hAAAA_AAAA, 5'd0, 1, 32'h0000_2000, 32'd2);
    apply("R8", 1, A_MCAUSE, 3'b010, 32'hF000_0000, 5'd0, 1, 32'h0000_3000, 32'd7);
    apply("R8", 1, A_MIE, 3'b001, 32'h0000_0080, 5'd0, 1, 32'h0000_4000, 32'd11);
    read_all("R8");

    // R9: MEPC written only by address match
    apply("R9", 1, A_MEPC, 3'b001, 32'h0000_5554, 5'd0, 0, 0, 0);
    apply("R9", 1, A_MCAUSE, 3'b001, 32'h0000_0003, 5'd0, 0, 0, 0);
    read_all("R9");

    // R10: unmapped address
    apply("R10", 1, A_NONE, 3'b001, 32'h1111_1111, 5'd0, 0, 0, 0);
    apply("R10", 1, 12'h343, 3'b110, 32'd0, 5'h1F, 0, 0, 0);
    idle_read("R10", A_NONE);
    read_all("R10");

    // R11: invalid operation codes
    apply("R11", 1, A_MTVEC, 3'b000, 32'h2222_2222, 5'd0, 0, 0, 0);
    apply("R11", 1, A_MEPC, 3'b100, 32'h3333_3333, 5'h1F, 0, 0, 0);
    read_all("R11");

    // R12 with R8 and R6: random mix against the model
    for (int i = 0; i < 400; i++) begin
      logic [11:0] ra;
      int sel;
      sel = $urandom_range(0, 6);
      case (sel)
        0: ra = A_MIE;
        1: ra = A_MTVEC;
        2: ra = A_MSCR;
        3: ra = A_MEPC;
        4: ra = A_MCAUSE;
        5: ra = A_NONE;
        default: ra = 12'h7C0;
      endcase
      apply("R12", 1'($urandom_range(0, 3) != 0), ra, 3'($urandom),
            $urandom, 5'($urandom), 1'($urandom_range(0, 5) == 0),
            $urandom, $urandom);
    end
    read_all("R12");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule